// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block turns four asynchronous external interrupt pins into four clean request lines for a downstream priority encoder. Each pin first passes through a synchroniser. A per-line detector then applies one of four sense types: active-high level, active-low level, rising edge or falling edge. When a line uses an edge type, a detected edge sets a sticky flag, and that flag stays set until software clears it. Each line has its own enable bit. One global master enable gates all four lines.

All configuration sits in one 32-bit control word, which a simple write-strobe and read-data port exposes. Writing a 1 to a line's clear bit drops that line's sticky edge flag in the same cycle as the write. The clear bits do not store their value, so they always read back as 0. The control word also holds a critical-source routing bit. This block does not use that bit; it only stores it and returns it on reads.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0x00000000 and all request outputs are 0.
- R2: The control word keeps bits 23:16 (sense types), bit 12 (master enable), bits 11:8 (line enables) and bit 0 (routing bit), and returns them on reg_rdata. Every other bit reads 0, and this includes the write-1-to-clear bits 27:24. Writing 0xFFFFFFFF therefore reads back 0x00FF1F01.
- R3: Line n takes its sense type from bits (23-2n):(22-2n). Type 0 is active-high level. With that type, the request follows the pin, and a pin change reaches the output after exactly two rising clock edges.
- R4: Sense type 3 is active-low level. The request is asserted while the synchronised pin is 0.
- R5: Sense type 1 is rising edge. A 0-to-1 change of the synchronised pin sets the line's flag, and the request stays high after the pin returns to 0.
- R6: Sense type 2 is falling edge. A 1-to-0 change of the synchronised pin sets the line's flag, which is held until it is cleared.
- R7: Writing a 1 to bit 27-n clears the edge flag of line n only. Writing 0 there leaves the flag alone. If an edge is detected in the same cycle as the clear, the edge wins.
- R8: Level-sensitive lines (types 0 and 3) ignore their clear bit. The request keeps tracking the pin.
- R9: The request of line n is forced to 0 while enable bit 11-n is 0. An edge that arrives while the line is disabled is still latched, and it shows up as a request once the line is enabled.
- R10: While master enable bit 12 is 0, all requests are 0. Latched edge flags are kept and reappear when the master enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word contents |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| irq_req_o | output | 4 | Conditioned request per line |

## Verification
The bench runs every line through every sense type, using the same pin pattern each time: low, high, low, then a clear. The expected request vector is computed from the sense code.

Several kinds of error would show up in that sweep:
- A design that swaps the edge polarities, or that decodes the sense field for a line from the wrong bit pair, lights the wrong line or the wrong phase.
- A design whose clear also acts on level lines drops a request that should persist.
- A design that clears every line's flag on any clear write loses a neighbour's pending edge in the isolation test.

Directed cases add three more checks. One tests the exact two-edge latency. One latches an edge while the line is disabled; a design that gates the detector instead of the output would never report that edge. The last checks that flags survive a master-enable toggle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int unsigned CTRL_W     = 32;
   localparam int unsigned MAX_LINES  = 4;
   localparam int unsigned MASTER_BIT = 12;
   localparam int unsigned ROUTE_BIT  = 0;
   localparam int unsigned SENSE_TOP  = 22;  // line n sense lsb = SENSE_TOP - 2n
   localparam int unsigned EN_TOP     = 11;  // line n enable   = EN_TOP - n
   localparam int unsigned CLR_TOP    = 27;  // line n clear    = CLR_TOP - n

   typedef enum logic [1:0] {
      SENSE_LVL_HI = 2'd0,
      SENSE_RISE   = 2'd1,
      SENSE_FALL   = 2'd2,
      SENSE_LVL_LO = 2'd3
   } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
   import ext_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  logic [1:0] sense_i,
   input  logic       clr_i,
   output logic       req_o
);
   logic prev_q;
   logic flag_q;
   logic rise;
   logic fall;
   logic hit;

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;
   assign hit  = ((sense_i == SENSE_RISE) & rise) | ((sense_i == SENSE_FALL) & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         if (hit)        flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (sense_i)
         SENSE_LVL_HI: req_o = lvl_i;
         SENSE_LVL_LO: req_o = ~lvl_i;
         default:      req_o = flag_q;
      endcase
   end
endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
   import ext_irq_pkg::*;
#(
   parameter int unsigned N_LINES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_i,
   input  logic [CTRL_W-1:0]       wdata_i,
   output logic [CTRL_W-1:0]       rdata_o,
   output logic [N_LINES-1:0][1:0] sense_o,
   output logic [N_LINES-1:0]      en_o,
   output logic                    master_o,
   output logic [N_LINES-1:0]      clr_o
);
   logic [N_LINES-1:0][1:0] sense_q;
   logic [N_LINES-1:0]      en_q;
   logic                    master_q;
   logic                    route_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         route_q  <= 1'b0;
      end else if (wr_i) begin
         master_q <= wdata_i[MASTER_BIT];
         route_q  <= wdata_i[ROUTE_BIT];
      end
   end

   generate
      for (genvar g = 0; g < int'(N_LINES); g++) begin : g_line
         localparam int unsigned SLSB = SENSE_TOP - 2 * g;
         localparam int unsigned EBIT = EN_TOP - g;
         localparam int unsigned CBIT = CLR_TOP - g;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sense_q[g] <= 2'd0;
               en_q[g]    <= 1'b0;
            end else if (wr_i) begin
               sense_q[g] <= wdata_i[SLSB +: 2];
               en_q[g]    <= wdata_i[EBIT];
            end
         end

         assign clr_o[g] = wr_i & wdata_i[CBIT];
      end
   endgenerate

   always_comb begin
      rdata_o             = '0;
      rdata_o[MASTER_BIT] = master_q;
      rdata_o[ROUTE_BIT]  = route_q;
      for (int n = 0; n < int'(N_LINES); n++) begin
         rdata_o[SENSE_TOP - 2*n +: 2] = sense_q[n];
         rdata_o[EN_TOP - n]           = en_q[n];
      end
   end

   assign sense_o  = sense_q;
   assign en_o     = en_q;
   assign master_o = master_q;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import ext_irq_pkg::*;
#(
   parameter int unsigned N_LINES     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [N_LINES-1:0]  pin_i,
   output logic [N_LINES-1:0]  irq_req_o
);
   generate
      if (N_LINES < 1 || N_LINES > MAX_LINES) begin : g_bad_lines
         $error("ext_irq_cond: N_LINES must be 1..4");
      end
   endgenerate

   logic [N_LINES-1:0]      pin_sync;
   logic [N_LINES-1:0][1:0] sense;
   logic [N_LINES-1:0]      line_en;
   logic [N_LINES-1:0]      line_clr;
   logic [N_LINES-1:0]      line_req;
   logic                    master;

   ext_irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (pin_sync)
   );

   ext_irq_ctrl_reg #(.N_LINES(N_LINES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .wdata_i  (reg_wdata),
      .rdata_o  (reg_rdata),
      .sense_o  (sense),
      .en_o     (line_en),
      .master_o (master),
      .clr_o    (line_clr)
   );

   generate
      for (genvar g = 0; g < int'(N_LINES); g++) begin : g_det
         ext_irq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (pin_sync[g]),
            .sense_i (sense[g]),
            .clr_i   (line_clr[g]),
            .req_o   (line_req[g])
         );
      end
   endgenerate

   assign irq_req_o = line_req & line_en & {N_LINES{master}};
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
   parameter int unsigned N_LINES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [31:0]        reg_rdata,
   input logic [N_LINES-1:0] pin_sync,
   input logic [N_LINES-1:0] irq_req_o
);
   p_master_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[12] |-> (irq_req_o == '0));

   p_unkept_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[31:24] == 8'h00) && (reg_rdata[15:13] == 3'b000) && (reg_rdata[7:1] == 7'h00));

   generate
      for (genvar g = 0; g < int'(N_LINES); g++) begin : g_chk
         localparam int unsigned SLSB = 22 - 2 * g;
         localparam int unsigned EBIT = 11 - g;

         p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_rdata[EBIT] |-> !irq_req_o[g]);

         p_level_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdata[SLSB +: 2] == 2'd0 && reg_rdata[EBIT] && reg_rdata[12])
            |-> (irq_req_o[g] == pin_sync[g]));

         p_level_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rdata[SLSB +: 2] == 2'd3 && reg_rdata[EBIT] && reg_rdata[12])
            |-> (irq_req_o[g] == !pin_sync[g]));

         p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((reg_rdata[SLSB +: 2] == 2'd1 || reg_rdata[SLSB +: 2] == 2'd2)
             && irq_req_o[g] && !reg_wr) |=> irq_req_o[g]);
      end
   endgenerate
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N_LINES(N_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata),
   .pin_sync  (pin_sync),
   .irq_req_o (irq_req_o)
);

// File: tb/ext_irq_cond_tb.sv
`timescale 1ns/1ps
module ext_irq_cond_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  pin_i = '0;
   logic [3:0]  irq_req_o;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   ext_irq_cond u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_i     (pin_i),
      .irq_req_o (irq_req_o)
   );

   localparam logic [31:0] MASTER = 32'h0000_1000;

   function automatic logic [31:0] en_bit(input int n);
      return 32'h1 << (11 - n);
   endfunction
   function automatic logic [31:0] sense_f(input int n, input int t);
      return 32'(t) << (22 - 2*n);
   endfunction
   function automatic logic [31:0] clr_bit(input int n);
      return 32'h1 << (27 - n);
   endfunction
   function automatic string type_tag(input int t);
      case (t)
         0: return "R3";
         1: return "R5";
         2: return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      #1;
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] cfg;
      cyc(3);
      // R1: reset state
      chk("R1 ctrl in reset", reg_rdata, 32'h0);
      chk("R1 req in reset", {28'h0, irq_req_o}, 32'h0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 ctrl after reset", reg_rdata, 32'h0);
      chk("R1 req after reset", {28'h0, irq_req_o}, 32'h0);

      // R2: readback of kept fields only
      wr(32'hFFFF_FFFF);
      chk("R2 readback all ones", reg_rdata, 32'h00FF_1F01);
      wr(32'h0000_0000);
      chk("R2 readback zero", reg_rdata, 32'h0);

      // R3: exact two-edge latency of a level line
      wr(MASTER | en_bit(0) | sense_f(0, 0));
      pin_i[0] = 1'b1;
      cyc(1);
      chk("R3 one edge after pin rise", {28'h0, irq_req_o}, 32'h0);
      cyc(1);
      chk("R3 two edges after pin rise", {28'h0, irq_req_o}, 32'h1);
      // R8: clear write on a level line is ignored
      wr(MASTER | en_bit(0) | sense_f(0, 0) | clr_bit(0));
      chk("R8 level high ignores clear", {28'h0, irq_req_o}, 32'h1);
      pin_i[0] = 1'b0;
      cyc(4);

      // sweep every line through every sense type
      for (int n = 0; n < 4; n++) begin
         for (int t = 0; t < 4; t++) begin
            cfg = MASTER | en_bit(n) | sense_f(n, t);
            wr(cfg | 32'h0F00_0000);
            chk({type_tag(t), " pin low"}, {28'h0, irq_req_o}, (t == 3) ? (32'h1 << n) : 32'h0);
            pin_i[n] = 1'b1;
            cyc(4);
            chk({type_tag(t), " pin high"}, {28'h0, irq_req_o}, (t <= 1) ? (32'h1 << n) : 32'h0);
            pin_i[n] = 1'b0;
            cyc(4);
            chk({type_tag(t), " pin back low"}, {28'h0, irq_req_o}, (t != 0) ? (32'h1 << n) : 32'h0);
            wr(cfg | clr_bit(n));
            chk({(t == 3) ? "R8" : "R7", " after clear"}, {28'h0, irq_req_o},
                (t == 3) ? (32'h1 << n) : 32'h0);
         end
      end

      // R7: clearing one line leaves a neighbour's flag
      cfg = MASTER | en_bit(0) | en_bit(1) | sense_f(0, 1) | sense_f(1, 1);
      wr(cfg | 32'h0F00_0000);
      pin_i[1:0] = 2'b11;
      cyc(4);
      pin_i[1:0] = 2'b00;
      cyc(4);
      chk("R7 both flags set", {28'h0, irq_req_o}, 32'h3);
      wr(cfg);
      chk("R7 zero clear bits keep flags", {28'h0, irq_req_o}, 32'h3);
      wr(cfg | clr_bit(0));
      chk("R7 clear line0 only", {28'h0, irq_req_o}, 32'h2);

      // R10: master off hides flags, master on restores them
      wr(cfg & ~MASTER);
      chk("R10 master off", {28'h0, irq_req_o}, 32'h0);
      pin_i[3] = 1'b1;
      cyc(4);
      chk("R10 master off level pin", {28'h0, irq_req_o}, 32'h0);
      pin_i[3] = 1'b0;
      cyc(4);
      wr(cfg);
      chk("R10 master back on", {28'h0, irq_req_o}, 32'h2);

      // R9: edge latched while disabled, reported after enable
      cfg = MASTER | sense_f(2, 2);
      wr(cfg | 32'h0F00_0000);
      pin_i[2] = 1'b1;
      cyc(4);
      pin_i[2] = 1'b0;
      cyc(4);
      chk("R9 disabled line silent", {28'h0, irq_req_o}, 32'h0);
      wr(cfg | en_bit(2));
      chk("R9 pending edge after enable", {28'h0, irq_req_o}, 32'h4);
      wr(cfg);
      chk("R9 disabled again", {28'h0, irq_req_o}, 32'h0);

      cyc(2);
      finish_run();
   end
endmodule